// File: doc/BRIEF.md
# Interrupt Source Capture Bank

This block turns a bank of asynchronous interrupt request lines into sticky pending bits. Each line gets its own detection mode: rising edge, falling edge, active-high level or active-low level. A captured event stays pending until software removes it. Each source also has an enable bit. The block drives a registered vector that is the AND of pending, enable and one global enable. A downstream prioritizer consumes that vector.

Software reaches the bank through a small synchronous register bus. The bus uses word addresses and 32-bit data.

Single bits are changed by writing a source number to an index register. One index register clears a pending bit, one sets an enable and one clears an enable. Whole 32-source words are cleared by writing a mask to a bulk register, where each 1 clears a bit.

Input lines pass through a two-stage synchronizer and a history flop before detection.

Top module: `irqcap_bank`

## Requirements
- R1: Each source has a mode bit and a sense bit. Mode 1 selects edge detection and mode 0 selects level detection. Sense 1 selects rising edge or active-high, and sense 0 selects falling edge or active-low. Source n sits at bit n%32 of word n/32. The sense words start at word address 12 and the mode words start at word address 16. Both are read/write.
- R2: In edge mode a source's pending bit is set by one qualifying transition of its input. The opposite transition does not set it. After the pending bit is cleared, it stays clear while the input holds its new level.
- R3: In level mode the pending bit is set in every cycle the input is at its active level. If it is cleared while the input is still active, it is set again one cycle later.
- R4: Writing source number n to word address 1 clears the pending bit of source n only. A clear beats a detection in the same cycle.
- R5: Writing n to word address 2 sets the enable of source n. Writing n to word address 3 clears it. No other enable changes.
- R6: A write to word address 4+w clears every pending bit of word w whose data bit is 1. A write to word address 8+w does the same for enable bits. Reading these addresses returns the pending word or the enable word.
- R7: An index write (word addresses 1, 2, 3) whose data is equal to or greater than the source count changes nothing.
- R8: Bit 0 of word address 0 is the global enable. While it is 0, `irq_out` is all zero, but pending bits are kept and reappear when it returns to 1.
- R9: `irq_out[n]` is a registered copy of global enable AND enable[n] AND pending[n].
- R10: A qualifying input change reaches `irq_out` on the fourth rising clock edge after the input changes.
- R11: After reset, the enables, pending bits, sense bits, mode bits and global enable are all 0. A read presents its data on `bus_rdata` after the edge that samples `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Asynchronous interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_SRC | Enabled, pending and globally enabled sources |

## Verification
Every one of the four modes is driven with both its qualifying transition and either the opposite transition or a steady level. This separates a correct sense/mode decode from a swapped or ignored bit.

The sources used lie in both register words and at both ends of each word. This catches a wrong word or bit position.

Level sources are cleared while still active and must reappear one cycle later. Edge sources are cleared while held and must stay clear. This shows whether the pending logic re-arms from the level or from the transition.

Index writes just past the source count, and bulk masks with a single bit, show whether a write reaches more than one source.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;
  localparam int ADDR_W = 5;
  localparam int WORD_W = 32;
  localparam logic [ADDR_W-1:0] ADR_GCTRL     = 5'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT_ICLR = 5'd1;
  localparam logic [ADDR_W-1:0] ADR_EN_ISET   = 5'd2;
  localparam logic [ADDR_W-1:0] ADR_EN_ICLR   = 5'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT_BASE = 5'd4;
  localparam logic [ADDR_W-1:0] ADR_EN_BASE   = 5'd8;
  localparam logic [ADDR_W-1:0] ADR_SNS_BASE  = 5'd12;
  localparam logic [ADDR_W-1:0] ADR_MODE_BASE = 5'd16;
endpackage

// File: rtl/irqcap_sync.sv
module irqcap_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] smp_o,
  output logic [WIDTH-1:0] prv_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      smp_o  <= '0;
      prv_o  <= '0;
    end else begin
      meta_q <= raw_i;
      smp_o  <= meta_q;
      prv_o  <= smp_o;
    end
  end
endmodule

// File: rtl/irqcap_regs.sv
module irqcap_regs
  import irqcap_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] stat_i,
  output logic               glb_en_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] sns_o,
  output logic [NUM_SRC-1:0] mode_o,
  output logic [NUM_SRC-1:0] stat_clr_o
);
  localparam int NUM_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int PAD_W     = NUM_WORDS * WORD_W;
  localparam int IDX_W     = $clog2(PAD_W);
  localparam logic [PAD_W-1:0] VALID = PAD_W'({NUM_SRC{1'b1}});

  logic [PAD_W-1:0] en_q, sns_q, mode_q, sns_d, mode_d;
  logic [PAD_W-1:0] idx_hot, en_set, en_clr, stat_clr, stat_pad;
  logic [WORD_W-1:0] rd_c;
  logic idx_ok;

  assign idx_ok   = bus_wdata < WORD_W'(NUM_SRC);
  assign stat_pad = PAD_W'(stat_i);

  always_comb begin
    idx_hot = '0;
    if (idx_ok) idx_hot[bus_wdata[IDX_W-1:0]] = 1'b1;
    en_set   = (bus_wr && bus_addr == ADR_EN_ISET)   ? idx_hot : '0;
    en_clr   = (bus_wr && bus_addr == ADR_EN_ICLR)   ? idx_hot : '0;
    stat_clr = (bus_wr && bus_addr == ADR_STAT_ICLR) ? idx_hot : '0;
    sns_d    = sns_q;
    mode_d   = mode_q;
    rd_c     = '0;
    if (bus_addr == ADR_GCTRL) rd_c = WORD_W'(glb_en_o);
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (bus_wr && bus_addr == ADR_EN_BASE + ADDR_W'(w))
        en_clr[w*WORD_W +: WORD_W] = bus_wdata;
      if (bus_wr && bus_addr == ADR_STAT_BASE + ADDR_W'(w))
        stat_clr[w*WORD_W +: WORD_W] = bus_wdata;
      if (bus_wr && bus_addr == ADR_SNS_BASE + ADDR_W'(w))
        sns_d[w*WORD_W +: WORD_W] = bus_wdata;
      if (bus_wr && bus_addr == ADR_MODE_BASE + ADDR_W'(w))
        mode_d[w*WORD_W +: WORD_W] = bus_wdata;
      if (bus_addr == ADR_STAT_BASE + ADDR_W'(w)) rd_c = stat_pad[w*WORD_W +: WORD_W];
      if (bus_addr == ADR_EN_BASE + ADDR_W'(w))   rd_c = en_q[w*WORD_W +: WORD_W];
      if (bus_addr == ADR_SNS_BASE + ADDR_W'(w))  rd_c = sns_q[w*WORD_W +: WORD_W];
      if (bus_addr == ADR_MODE_BASE + ADDR_W'(w)) rd_c = mode_q[w*WORD_W +: WORD_W];
    end
    sns_d  = sns_d & VALID;
    mode_d = mode_d & VALID;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en_o  <= 1'b0;
      en_q      <= '0;
      sns_q     <= '0;
      mode_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == ADR_GCTRL) glb_en_o <= bus_wdata[0];
      en_q   <= (en_q | en_set) & ~en_clr;
      sns_q  <= sns_d;
      mode_q <= mode_d;
      if (bus_rd) bus_rdata <= rd_c;
    end
  end

  assign en_o       = en_q[NUM_SRC-1:0];
  assign sns_o      = sns_q[NUM_SRC-1:0];
  assign mode_o     = mode_q[NUM_SRC-1:0];
  assign stat_clr_o = stat_clr[NUM_SRC-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_en_chk
    AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADR_EN_ISET && bus_wdata == WORD_W'(i)) |=> en_o[i]); // R5
    AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADR_EN_ICLR && bus_wdata == WORD_W'(i)) |=> !en_o[i]); // R5
  end
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADR_EN_ISET && !idx_ok) |=> $stable(en_q)); // R7
endmodule

// File: rtl/irqcap_status.sv
module irqcap_status #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] smp_i,
  input  logic [NUM_SRC-1:0] prv_i,
  input  logic [NUM_SRC-1:0] sns_i,
  input  logic [NUM_SRC-1:0] mode_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               glb_en_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_SRC-1:0] irq_o
);
  logic [NUM_SRC-1:0] det;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_comb begin
      if (mode_i[i]) det[i] = sns_i[i] ? (smp_i[i] & ~prv_i[i]) : (~smp_i[i] & prv_i[i]);
      else           det[i] = ~(smp_i[i] ^ sns_i[i]);
    end

    always_ff @(posedge clk) begin
      if (rst)           stat_o[i] <= 1'b0;
      else if (clr_i[i]) stat_o[i] <= 1'b0;
      else if (det[i])   stat_o[i] <= 1'b1;
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
      clr_i[i] |=> !stat_o[i]); // R4
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!mode_i[i] && (smp_i[i] == sns_i[i]) && !clr_i[i]) |=> stat_o[i]); // R3
    AST_EDGE_CAUSE: assert property (@(posedge clk) disable iff (rst)
      ($past(mode_i[i]) && $rose(stat_o[i])) |-> ($past(smp_i[i]) != $past(prv_i[i]))); // R2
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= glb_en_i ? (stat_o & en_i) : '0;
  end

  AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
    !glb_en_i |=> (irq_o == '0)); // R8
  AST_OUT_SUBSET: assert property (@(posedge clk) disable iff (rst)
    ((irq_o & ~$past(stat_o & en_i)) == '0)); // R9
endmodule

// File: rtl/irqcap_bank.sv
module irqcap_bank
  import irqcap_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [4:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_SRC-1:0] irq_out
);
  logic [NUM_SRC-1:0] smp, prv, en, sns, mode, stat, stat_clr;
  logic glb_en;

  irqcap_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk(clk), .rst(rst), .raw_i(irq_in), .smp_o(smp), .prv_o(prv)
  );

  irqcap_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stat_i(stat), .glb_en_o(glb_en), .en_o(en), .sns_o(sns),
    .mode_o(mode), .stat_clr_o(stat_clr)
  );

  irqcap_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk(clk), .rst(rst), .smp_i(smp), .prv_i(prv), .sns_i(sns),
    .mode_i(mode), .en_i(en), .clr_i(stat_clr), .glb_en_i(glb_en),
    .stat_o(stat), .irq_o(irq_out)
  );
endmodule

// File: tb/irqcap_bank_tb.sv
module irqcap_bank_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_out;
  int n_chk = 0, n_err = 0;
  logic [63:0] sns_sh = '0, mode_sh = '0;
  logic [31:0] rv, rv2, e0, e1;

  always #5 clk = ~clk;

  irqcap_bank #(.NUM_SRC(64)) dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  // fields: src[11:5], sense[4], mode[3], level before[2], level after[1], expected pending[0]
  localparam logic [11:0] VEC [10] = '{
    {7'd5,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'd5,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {7'd37, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {7'd37, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {7'd63, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {7'd63, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {7'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {7'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {7'd32, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {7'd31, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic put_cfg(input int s);
    int w;
    w = s / 32;
    wr(5'(12 + w), sns_sh[w*32 +: 32]);
    wr(5'(16 + w), mode_sh[w*32 +: 32]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 irq_out after reset", irq_out, 64'h0);
    rd(5'd0, rv);  chk("R11 global enable reset", 64'(rv), 64'h0);
    rd(5'd8, rv);  chk("R11 enable word0 reset", 64'(rv), 64'h0);
    rd(5'd13, rv); chk("R11 sense word1 reset", 64'(rv), 64'h0);
    rd(5'd16, rv); chk("R11 mode word0 reset", 64'(rv), 64'h0);

    // setup: all sources level-high, inputs low, pending cleared, global on
    sns_sh = '1;
    wr(5'd12, 32'hffff_ffff);
    wr(5'd13, 32'hffff_ffff);
    idle(6);
    wr(5'd4, 32'hffff_ffff);
    wr(5'd5, 32'hffff_ffff);
    wr(5'd0, 32'h1);
    rd(5'd12, rv); chk("R1 sense word0 readback", 64'(rv), 64'hffff_ffff);

    // table walk over modes (R1, R2, R3, R9)
    for (int v = 0; v < 10; v++) begin
      int s;
      logic lv0, lv1, ex;
      s   = int'(VEC[v][11:5]);
      lv0 = VEC[v][2]; lv1 = VEC[v][1]; ex = VEC[v][0];
      irq_in[s] = lv0;
      idle(6);
      sns_sh[s] = VEC[v][4]; mode_sh[s] = VEC[v][3];
      put_cfg(s);
      idle(2);
      wr(5'(4 + s / 32), 32'h1 << (s % 32));
      irq_in[s] = lv1;
      idle(6);
      rd(5'(4 + s / 32), rv);
      chk(VEC[v][3] ? "R2 edge capture" : "R3 level capture", 64'(rv[s % 32]), 64'(ex));
      wr(5'd2, 32'(s));
      idle(2);
      chk("R9 irq_out follows enabled pending", 64'(irq_out[s]), 64'(ex));
      wr(5'd3, 32'(s));
      sns_sh[s] = 1'b1; mode_sh[s] = 1'b0; irq_in[s] = 1'b0;
      put_cfg(s);
      idle(6);
      wr(5'(4 + s / 32), 32'h1 << (s % 32));
    end

    // R3 level clear while active re-sets one cycle later
    irq_in[10] = 1'b1;
    idle(6);
    wr(5'd2, 32'd10);
    idle(3);
    chk("R3 level source active", 64'(irq_out[10]), 64'h1);
    wr(5'd1, 32'd10);
    @(negedge clk);
    chk("R3 dip after clear", 64'(irq_out[10]), 64'h0);
    @(negedge clk);
    chk("R3 re-set next cycle", 64'(irq_out[10]), 64'h1);

    // R4 index clear hits only its source
    irq_in[11] = 1'b1;
    idle(6);
    irq_in[10] = 1'b0; irq_in[11] = 1'b0;
    idle(6);
    wr(5'd1, 32'd10);
    rd(5'd4, rv);
    chk("R4 index clear only source 10", 64'(rv[11:10]), 64'h2);

    // R8 global enable gates output but keeps pending
    wr(5'd2, 32'd11);
    idle(2);
    chk("R8 irq_out with global on", 64'(irq_out[11]), 64'h1);
    wr(5'd0, 32'h0);
    idle(2);
    chk("R8 irq_out forced low", irq_out, 64'h0);
    rd(5'd4, rv);
    chk("R8 pending kept", 64'(rv[11]), 64'h1);
    wr(5'd0, 32'h1);
    idle(2);
    chk("R8 pending returns", 64'(irq_out[11]), 64'h1);

    // R7 out-of-range index writes ignored
    rd(5'd8, e0); rd(5'd9, e1);
    wr(5'd2, 32'd64);
    wr(5'd2, 32'd100);
    wr(5'd3, 32'd75);
    rd(5'd8, rv); rd(5'd9, rv2);
    chk("R7 enables unchanged", {rv2, rv}, {e1, e0});
    wr(5'd1, 32'd64);
    rd(5'd4, rv);
    chk("R7 pending unchanged", 64'(rv[11]), 64'h1);

    // R6 bulk clears
    irq_in[40] = 1'b1;
    idle(6);
    irq_in[40] = 1'b0;
    wr(5'd2, 32'd40);
    wr(5'd4, 32'h0000_0800);
    rd(5'd4, rv); rd(5'd5, rv2);
    chk("R6 bulk pending clear", {rv2[8], rv[11]}, 64'h2);
    wr(5'd8, 32'h0000_0800);
    rd(5'd8, rv); rd(5'd9, rv2);
    chk("R6 bulk enable clear", {rv2[8], rv[11]}, 64'h2);
    chk("R6 other source output kept", 64'(irq_out[40]), 64'h1);

    // R10 latency
    wr(5'd2, 32'd20);
    @(negedge clk);
    irq_in[20] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 not yet after three edges", 64'(irq_out[20]), 64'h0);
    @(negedge clk);
    chk("R10 visible after fourth edge", 64'(irq_out[20]), 64'h1);

    // R2 edge cleared while held stays clear
    mode_sh[22] = 1'b1;
    put_cfg(22);
    idle(2);
    irq_in[22] = 1'b1;
    idle(6);
    rd(5'd4, rv);
    chk("R2 rising edge pending", 64'(rv[22]), 64'h1);
    wr(5'd1, 32'd22);
    idle(4);
    rd(5'd4, rv);
    chk("R2 edge stays clear while held", 64'(rv[22]), 64'h0);
    rd(5'd16, rv);
    chk("R1 mode word readback", 64'(rv), 64'h0040_0000);

    summary();
    $finish;
  end
endmodule